// File: doc/BRIEF.md
# Full-Frame CCD Capture Sequencer

This block runs one capture of a full-frame CCD sensor from a single start pulse. It first holds the shutter open for a programmed number of cycles while no charge is moved. It then empties the array one row at a time. Each row is moved into the serial register by a parallel-shift request, and every pixel of that row is then moved to the output amplifier by a serial-shift request. Each request is held until the external phase-clock generator reports that the shift is complete.

A rectangular region of interest decides which pixels are converted. For a pixel inside the region, a sample strobe goes to the ADC one cycle after its serial shift completes. The ADC result returns a fixed number of cycles later and leaves the block with its row and column index. Pixels outside the region are still shifted out but are never converted. After the readout pass, the block repeats every parallel and serial shift without any conversion, to clear residual charge before the next exposure.

Top module: `ccd_readout_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy_o, shutter_o, pshift_req_o, sshift_req_o, adc_strobe_o and pix_valid_o are all 0.
- R2: A start_i pulse while idle raises busy_o and shutter_o in the next cycle. shutter_o stays high for exactly max(exp_len_i,1) cycles, and no shift request is issued while it is high or before it has closed.
- R3: The readout pass issues rows_i parallel shifts. After each completed parallel shift, exactly cols_i serial shifts complete before the next parallel shift completes.
- R4: A shift request stays high until shift_done_i is sampled high with it, and parallel and serial requests are never high together. A parallel request drops in the cycle after its completion.
- R5: adc_strobe_o is high for one cycle exactly one cycle after a serial shift completes in the readout pass, and only for a pixel inside the region. Rows are numbered from 0 in the order they are shifted out, and columns from 0 in the order pixels leave the serial register. A pixel is inside when roi_row_lo_i <= row <= roi_row_hi_i and roi_col_lo_i <= col <= roi_col_hi_i.
- R6: pix_valid_o rises exactly ADC_LAT cycles after each strobe. In that cycle pix_row_o and pix_col_o give the strobed pixel and pix_data_o equals adc_data_i (12 bits, 0 to 4095). Pixels therefore come out in raster order: columns ascending within a row, rows ascending.
- R7: After the readout pass, a clear pass repeats rows_i parallel shifts, each followed by cols_i serial shifts, and issues no strobe.
- R8: busy_o stays high from the cycle after start until the cycle after the last clear-pass serial shift completes. A start_i pulse while busy_o is high has no effect.
- R9: Exposure length, array size and region bounds are sampled at start. Changes to those inputs during a frame have no effect on that frame.
- R10: A rows_i or cols_i value of 0 is treated as 1. A region whose low bound exceeds its high bound selects no pixel, and bounds beyond the array edge are clipped to the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Capture start pulse |
| exp_len_i | input | EXP_W | Exposure length in cycles |
| rows_i | input | ROW_W | Rows in the array |
| cols_i | input | COL_W | Pixels per row |
| roi_row_lo_i | input | ROW_W | First row of region |
| roi_row_hi_i | input | ROW_W | Last row of region |
| roi_col_lo_i | input | COL_W | First column of region |
| roi_col_hi_i | input | COL_W | Last column of region |
| shift_done_i | input | 1 | Phase generator: current shift complete |
| adc_data_i | input | DATA_W | ADC conversion result |
| busy_o | output | 1 | Frame in progress |
| shutter_o | output | 1 | Shutter open |
| pshift_req_o | output | 1 | Parallel-register shift request |
| sshift_req_o | output | 1 | Serial-register shift request |
| adc_strobe_o | output | 1 | ADC sample strobe |
| pix_valid_o | output | 1 | Pixel result valid |
| pix_row_o | output | ROW_W | Row of pixel result |
| pix_col_o | output | COL_W | Column of pixel result |
| pix_data_o | output | DATA_W | Pixel value |

## Verification
The assertions check the local rules on every cycle: requests held until completion and never paired, no shift while the shutter is open, strobes only after a readout-pass serial completion, and every valid pixel preceded by an outstanding strobe. Counts and order can only be shown by whole frames in the bench. These include the number of parallel and serial shifts in each pass, the serial count between parallel shifts, the exact shutter width, the strobed pixel set and its raster order, and immunity to mid-frame input changes and repeated starts. The bench replays these against its own raster model over directed corner frames and random sizes, regions and phase-generator delays.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXPOSE = 2'd1,
    ST_PAR    = 2'd2,
    ST_SER    = 2'd3
  } seq_state_e;

  // Inclusive rectangle test; an inverted range holds no pixel.
  function automatic logic in_window(input logic [31:0] row, input logic [31:0] col,
                                     input logic [31:0] r_lo, input logic [31:0] r_hi,
                                     input logic [31:0] c_lo, input logic [31:0] c_hi);
    return (row >= r_lo) && (row <= r_hi) && (col >= c_lo) && (col <= c_hi);
  endfunction

  // A zero count means a single unit.
  function automatic logic [31:0] at_least_one(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/ccd_frame_cfg.sv
module ccd_frame_cfg #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [EXP_W-1:0] exp_len_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic [ROW_W-1:0] r_lo_i,
  input  logic [ROW_W-1:0] r_hi_i,
  input  logic [COL_W-1:0] c_lo_i,
  input  logic [COL_W-1:0] c_hi_i,
  output logic [EXP_W-1:0] exp_q,
  output logic [ROW_W-1:0] rows_q,
  output logic [COL_W-1:0] cols_q,
  output logic [ROW_W-1:0] r_lo_q,
  output logic [ROW_W-1:0] r_hi_q,
  output logic [COL_W-1:0] c_lo_q,
  output logic [COL_W-1:0] c_hi_q
);
  import ccd_seq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q  <= EXP_W'(1);
      rows_q <= ROW_W'(1);
      cols_q <= COL_W'(1);
      r_lo_q <= '0;
      r_hi_q <= '0;
      c_lo_q <= '0;
      c_hi_q <= '0;
    end else if (load_i) begin
      exp_q  <= EXP_W'(at_least_one(32'(exp_len_i)));
      rows_q <= ROW_W'(at_least_one(32'(rows_i)));
      cols_q <= COL_W'(at_least_one(32'(cols_i)));
      r_lo_q <= r_lo_i;
      r_hi_q <= r_hi_i;
      c_lo_q <= c_lo_i;
      c_hi_q <= c_hi_i;
    end
  end

endmodule

// File: rtl/ccd_shift_fsm.sv
module ccd_shift_fsm #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int EXP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             shift_done_i,
  input  logic [EXP_W-1:0] exp_q,
  input  logic [ROW_W-1:0] rows_q,
  input  logic [COL_W-1:0] cols_q,
  output logic             load_o,
  output logic             busy_o,
  output logic             shutter_o,
  output logic             pshift_req_o,
  output logic             sshift_req_o,
  output logic             clearing_o,
  output logic             ser_done_o,
  output logic [ROW_W-1:0] row_idx_o,
  output logic [COL_W-1:0] col_idx_o
);
  import ccd_seq_pkg::*;

  seq_state_e       state_q, state_d;
  logic [EXP_W-1:0] exp_cnt_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             clear_q;

  logic exp_last, row_last, col_last, par_done;

  assign exp_last = (exp_cnt_q == exp_q - EXP_W'(1));
  assign row_last = (row_q == rows_q - ROW_W'(1));
  assign col_last = (col_q == cols_q - COL_W'(1));

  assign busy_o       = (state_q != ST_IDLE);
  assign shutter_o    = (state_q == ST_EXPOSE);
  assign pshift_req_o = (state_q == ST_PAR);
  assign sshift_req_o = (state_q == ST_SER);
  assign par_done     = pshift_req_o && shift_done_i;
  assign ser_done_o   = sshift_req_o && shift_done_i;
  assign load_o       = (state_q == ST_IDLE) && start_i;
  assign clearing_o   = clear_q;
  assign row_idx_o    = row_q;
  assign col_idx_o    = col_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_EXPOSE;
      ST_EXPOSE: if (exp_last) state_d = ST_PAR;
      ST_PAR:    if (par_done) state_d = ST_SER;
      ST_SER: begin
        if (ser_done_o && col_last) begin
          if (row_last && clear_q) state_d = ST_IDLE;
          else                     state_d = ST_PAR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      exp_cnt_q <= '0;
      row_q     <= '0;
      col_q     <= '0;
      clear_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        ST_IDLE: begin
          exp_cnt_q <= '0;
          row_q     <= '0;
          col_q     <= '0;
          clear_q   <= 1'b0;
        end
        ST_EXPOSE: begin
          if (!exp_last) exp_cnt_q <= exp_cnt_q + EXP_W'(1);
        end
        ST_PAR: begin
          if (par_done) col_q <= '0;
        end
        ST_SER: begin
          if (ser_done_o) begin
            if (!col_last) begin
              col_q <= col_q + COL_W'(1);
            end else if (!row_last) begin
              row_q <= row_q + ROW_W'(1);
            end else begin
              row_q   <= '0;
              clear_q <= !clear_q;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ccd_sample_pipe.sv
module ccd_sample_pipe #(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int DATA_W  = 12,
  parameter int ADC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_done_i,
  input  logic              clearing_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [ROW_W-1:0]  r_lo_i,
  input  logic [ROW_W-1:0]  r_hi_i,
  input  logic [COL_W-1:0]  c_lo_i,
  input  logic [COL_W-1:0]  c_hi_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              strobe_o,
  output logic              pix_valid_o,
  output logic [ROW_W-1:0]  pix_row_o,
  output logic [COL_W-1:0]  pix_col_o,
  output logic [DATA_W-1:0] pix_data_o
);
  import ccd_seq_pkg::*;

  logic             hit;
  logic             stb_q;
  logic [ROW_W-1:0] stb_row_q;
  logic [COL_W-1:0] stb_col_q;

  logic             v_q   [ADC_LAT];
  logic [ROW_W-1:0] r_q   [ADC_LAT];
  logic [COL_W-1:0] c_q   [ADC_LAT];

  assign hit = ser_done_i && !clearing_i &&
               in_window(32'(row_i), 32'(col_i), 32'(r_lo_i), 32'(r_hi_i),
                         32'(c_lo_i), 32'(c_hi_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q     <= 1'b0;
      stb_row_q <= '0;
      stb_col_q <= '0;
    end else begin
      stb_q <= hit;
      if (hit) begin
        stb_row_q <= row_i;
        stb_col_q <= col_i;
      end
    end
  end

  for (genvar s = 0; s < ADC_LAT; s++) begin : g_lat
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          r_q[0] <= '0;
          c_q[0] <= '0;
        end else begin
          v_q[0] <= stb_q;
          r_q[0] <= stb_row_q;
          c_q[0] <= stb_col_q;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[s] <= 1'b0;
          r_q[s] <= '0;
          c_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1];
          r_q[s] <= r_q[s-1];
          c_q[s] <= c_q[s-1];
        end
      end
    end
  end

  assign strobe_o    = stb_q;
  assign pix_valid_o = v_q[ADC_LAT-1];
  assign pix_row_o   = r_q[ADC_LAT-1];
  assign pix_col_o   = c_q[ADC_LAT-1];
  assign pix_data_o  = pix_valid_o ? adc_data_i : '0;

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq #(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int EXP_W   = 16,
  parameter int DATA_W  = 12,
  parameter int ADC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [EXP_W-1:0]  exp_len_i,
  input  logic [ROW_W-1:0]  rows_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic [ROW_W-1:0]  roi_row_lo_i,
  input  logic [ROW_W-1:0]  roi_row_hi_i,
  input  logic [COL_W-1:0]  roi_col_lo_i,
  input  logic [COL_W-1:0]  roi_col_hi_i,
  input  logic              shift_done_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              busy_o,
  output logic              shutter_o,
  output logic              pshift_req_o,
  output logic              sshift_req_o,
  output logic              adc_strobe_o,
  output logic              pix_valid_o,
  output logic [ROW_W-1:0]  pix_row_o,
  output logic [COL_W-1:0]  pix_col_o,
  output logic [DATA_W-1:0] pix_data_o
);

  logic             load_w;
  logic             clearing_w;
  logic             ser_done_w;
  logic [EXP_W-1:0] exp_q;
  logic [ROW_W-1:0] rows_q, r_lo_q, r_hi_q, row_idx_w;
  logic [COL_W-1:0] cols_q, c_lo_q, c_hi_q, col_idx_w;

  ccd_frame_cfg #(.ROW_W(ROW_W), .COL_W(COL_W), .EXP_W(EXP_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_w),
    .exp_len_i (exp_len_i),
    .rows_i    (rows_i),
    .cols_i    (cols_i),
    .r_lo_i    (roi_row_lo_i),
    .r_hi_i    (roi_row_hi_i),
    .c_lo_i    (roi_col_lo_i),
    .c_hi_i    (roi_col_hi_i),
    .exp_q     (exp_q),
    .rows_q    (rows_q),
    .cols_q    (cols_q),
    .r_lo_q    (r_lo_q),
    .r_hi_q    (r_hi_q),
    .c_lo_q    (c_lo_q),
    .c_hi_q    (c_hi_q)
  );

  ccd_shift_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .EXP_W(EXP_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .shift_done_i (shift_done_i),
    .exp_q        (exp_q),
    .rows_q       (rows_q),
    .cols_q       (cols_q),
    .load_o       (load_w),
    .busy_o       (busy_o),
    .shutter_o    (shutter_o),
    .pshift_req_o (pshift_req_o),
    .sshift_req_o (sshift_req_o),
    .clearing_o   (clearing_w),
    .ser_done_o   (ser_done_w),
    .row_idx_o    (row_idx_w),
    .col_idx_o    (col_idx_w)
  );

  ccd_sample_pipe #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ADC_LAT(ADC_LAT)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_done_i  (ser_done_w),
    .clearing_i  (clearing_w),
    .row_i       (row_idx_w),
    .col_i       (col_idx_w),
    .r_lo_i      (r_lo_q),
    .r_hi_i      (r_hi_q),
    .c_lo_i      (c_lo_q),
    .c_hi_i      (c_hi_q),
    .adc_data_i  (adc_data_i),
    .strobe_o    (adc_strobe_o),
    .pix_valid_o (pix_valid_o),
    .pix_row_o   (pix_row_o),
    .pix_col_o   (pix_col_o),
    .pix_data_o  (pix_data_o)
  );

endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk #(
  parameter int ADC_LAT = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic shift_done_i,
  input logic busy_o,
  input logic shutter_o,
  input logic pshift_req_o,
  input logic sshift_req_o,
  input logic adc_strobe_o,
  input logic pix_valid_o,
  input logic clearing_w,
  input logic ser_done_w
);

  logic [7:0] outstanding_q;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding_q <= '0;
    else outstanding_q <= outstanding_q + {7'd0, adc_strobe_o} - {7'd0, pix_valid_o};
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy_o && !adc_strobe_o && !pix_valid_o);

  a_r2_no_shift_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    shutter_o |-> !pshift_req_o && !sshift_req_o);

  a_r2_open_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutter_o) |-> $past(start_i && !busy_o));

  a_r4_par_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pshift_req_o && !shift_done_i |=> pshift_req_o);

  a_r4_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sshift_req_o && !shift_done_i |=> sshift_req_o);

  a_r4_par_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pshift_req_o && shift_done_i |=> !pshift_req_o);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pshift_req_o && sshift_req_o));

  a_r5_strobe_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe_o |-> $past(ser_done_w));

  a_r7_no_strobe_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe_o |-> $past(!clearing_w));

  a_r6_valid_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid_o |-> outstanding_q != 8'd0);

  a_r6_bounded_latency: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding_q) <= ADC_LAT);

  a_r8_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (shutter_o || pshift_req_o || sshift_req_o) |-> busy_o);

endmodule

bind ccd_readout_seq ccd_readout_seq_chk #(.ADC_LAT(ADC_LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .shift_done_i (shift_done_i),
  .busy_o       (busy_o),
  .shutter_o    (shutter_o),
  .pshift_req_o (pshift_req_o),
  .sshift_req_o (sshift_req_o),
  .adc_strobe_o (adc_strobe_o),
  .pix_valid_o  (pix_valid_o),
  .clearing_w   (clearing_w),
  .ser_done_w   (ser_done_w)
);

// File: tb/test_ccd_readout_seq.sv
module test_ccd_readout_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 6, CW = 6, EW = 8, DW = 12, LAT = 2;
  localparam int WATCHDOG = 150000;

  logic clk = 0, rst_n = 0, start_i = 0, shift_done_i = 0;
  logic [EW-1:0] exp_len_i = '0;
  logic [RW-1:0] rows_i = '0, roi_row_lo_i = '0, roi_row_hi_i = '0;
  logic [CW-1:0] cols_i = '0, roi_col_lo_i = '0, roi_col_hi_i = '0;
  logic [DW-1:0] adc_data_i = '0;
  logic busy_o, shutter_o, pshift_req_o, sshift_req_o, adc_strobe_o, pix_valid_o;
  logic [RW-1:0] pix_row_o;
  logic [CW-1:0] pix_col_o;
  logic [DW-1:0] pix_data_o;

  ccd_readout_seq #(.ROW_W(RW), .COL_W(CW), .EXP_W(EW), .DATA_W(DW), .ADC_LAT(LAT)) i_ccd_readout_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int f_rows, f_cols, f_exp, f_r0, f_r1, f_c0, f_c1;
  int par_cnt, ser_cnt, stb_cnt, val_cnt, open_cnt;
  bit prev_hit, prev_pdone;
  int prev_r, prev_c;
  bit bv[LAT];
  int br[LAT], bc[LAT];
  int wait_cnt = 0, dly = 1;

  function automatic int hash(int r, int c);
    return (r * 37 + c * 11 + 5) % 4096;
  endfunction
  function automatic bit roi_hit(int r, int c);
    return r >= f_r0 && r <= f_r1 && c >= f_c0 && c <= f_c1;
  endfunction
  function automatic int roi_total();
    int n = 0;
    for (int r = 0; r < f_rows; r++)
      for (int c = 0; c < f_cols; c++)
        if (roi_hit(r, c)) n++;
    return n;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Phase generator, ADC model and cycle monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (pshift_req_o || sshift_req_o) begin
        if (wait_cnt >= dly) begin
          shift_done_i = 1; wait_cnt = 0; dly = 1 + int'($urandom % 3);
        end else begin
          shift_done_i = 0; wait_cnt++;
        end
      end else begin
        shift_done_i = 0; wait_cnt = 0;
      end
      adc_data_i = DW'(hash(br[LAT-1], bc[LAT-1]));
      #1;
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
      if (rst_n) begin
        // R6: result ADC_LAT cycles after strobe, raster order
        if (pix_valid_o || bv[LAT-1]) begin
          check(pix_valid_o == bv[LAT-1], "R6", "pix_valid", int'(pix_valid_o), int'(bv[LAT-1]));
          if (pix_valid_o && bv[LAT-1]) begin
            check(int'(pix_row_o) == br[LAT-1] && int'(pix_col_o) == bc[LAT-1], "R6", "pixel index",
                  int'(pix_row_o) * 1000 + int'(pix_col_o), br[LAT-1] * 1000 + bc[LAT-1]);
            check(int'(pix_data_o) == hash(br[LAT-1], bc[LAT-1]), "R6", "pixel data",
                  int'(pix_data_o), hash(br[LAT-1], bc[LAT-1]));
          end
          if (pix_valid_o) val_cnt++;
        end
        for (int i = LAT - 1; i > 0; i--) begin
          bv[i] = bv[i-1]; br[i] = br[i-1]; bc[i] = bc[i-1];
        end
        bv[0] = prev_hit; br[0] = prev_r; bc[0] = prev_c;
        // R5 / R7: strobe one cycle after an in-region readout serial shift
        if (adc_strobe_o || prev_hit)
          check(adc_strobe_o == prev_hit, "R5", "adc strobe", int'(adc_strobe_o), int'(prev_hit));
        if (adc_strobe_o) stb_cnt++;
        // R4
        if (pshift_req_o && sshift_req_o) check(0, "R4", "both requests", 1, 0);
        if (prev_pdone && pshift_req_o) check(0, "R4", "parallel request after done", 1, 0);
        // R2
        if (shutter_o) begin
          open_cnt++;
          if (par_cnt != 0 || ser_cnt != 0 || pshift_req_o || sshift_req_o)
            check(0, "R2", "shift activity with shutter open", par_cnt + ser_cnt, 0);
        end
        prev_hit = 0;
        if (sshift_req_o && shift_done_i) begin
          if (ser_cnt < f_rows * f_cols) begin
            prev_r = ser_cnt / f_cols; prev_c = ser_cnt % f_cols;
            prev_hit = roi_hit(prev_r, prev_c);
          end
          ser_cnt++;
        end
        prev_pdone = pshift_req_o && shift_done_i;
        if (prev_pdone) begin
          check(ser_cnt == par_cnt * f_cols, "R3", "serial count at parallel shift", ser_cnt, par_cnt * f_cols);
          par_cnt++;
        end
      end
    end
  end

  task automatic run_frame(int rows, int cols, int e, int r0, int r1, int c0, int c1, bit disturb);
    int lim;
    @(negedge clk);
    f_rows = rows == 0 ? 1 : rows; f_cols = cols == 0 ? 1 : cols; f_exp = e == 0 ? 1 : e;
    f_r0 = r0; f_r1 = r1; f_c0 = c0; f_c1 = c1;
    par_cnt = 0; ser_cnt = 0; stb_cnt = 0; val_cnt = 0; open_cnt = 0;
    rows_i = RW'(rows); cols_i = CW'(cols); exp_len_i = EW'(e);
    roi_row_lo_i = RW'(r0); roi_row_hi_i = RW'(r1); roi_col_lo_i = CW'(c0); roi_col_hi_i = CW'(c1);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    #2;
    check(busy_o && shutter_o, "R2", "busy and shutter after start", int'(busy_o) + int'(shutter_o), 2);
    if (disturb) begin
      // R9: inputs change mid-frame; R8: start while busy
      rows_i = RW'($urandom); cols_i = CW'($urandom); exp_len_i = EW'($urandom);
      roi_row_lo_i = '0; roi_row_hi_i = '1; roi_col_lo_i = '0; roi_col_hi_i = '1;
      for (int k = 0; k < 6; k++) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
      for (int k = 0; k < 40; k++) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
    end
    lim = 0;
    while (busy_o && lim < 20000) begin @(negedge clk); #2; lim++; end
    check(ser_cnt == 2 * f_rows * f_cols, "R7", "serial shifts both passes", ser_cnt, 2 * f_rows * f_cols);
    check(par_cnt == 2 * f_rows, "R3", "parallel shifts both passes", par_cnt, 2 * f_rows);
    check(open_cnt == f_exp, "R2", "shutter cycles", open_cnt, f_exp);
    check(stb_cnt == roi_total(), "R10", "strobe count", stb_cnt, roi_total());
    for (int k = 0; k < LAT + 3; k++) @(negedge clk);
    #2;
    check(val_cnt == roi_total(), "R6", "pixel count", val_cnt, roi_total());
    check(!busy_o && !shutter_o && open_cnt == f_exp, "R8", "idle after frame, late start ignored",
          int'(busy_o) + open_cnt, f_exp);
    if (disturb)
      check(ser_cnt == 2 * f_rows * f_cols && stb_cnt == roi_total(), "R9", "frame used sampled config",
            ser_cnt, 2 * f_rows * f_cols);
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0;
    repeat (3) @(negedge clk);
    #2;
    check(!busy_o && !shutter_o && !pshift_req_o && !sshift_req_o && !adc_strobe_o && !pix_valid_o,
          "R1", "outputs in reset", 1, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #2;
    check(!busy_o && !shutter_o && !pshift_req_o && !sshift_req_o && !adc_strobe_o && !pix_valid_o,
          "R1", "outputs after reset", 1, 0);
    run_frame(4, 5, 3, 0, 63, 0, 63, 0);   // R3 full region
    run_frame(0, 0, 0, 0, 0, 0, 0, 0);     // R10 zero sizes, zero exposure
    run_frame(5, 4, 2, 3, 1, 0, 3, 0);     // R10 inverted region
    run_frame(6, 7, 5, 1, 3, 2, 4, 1);     // R9 R8 disturbance
    run_frame(3, 3, 1, 2, 40, 1, 50, 0);   // R10 clipped region
    for (int n = 0; n < 6; n++) begin
      int r = 1 + int'($urandom % 12), c = 1 + int'($urandom % 12);
      int a = int'($urandom % 14), b = int'($urandom % 14);
      int d = int'($urandom % 14), g = int'($urandom % 14);
      run_frame(r, c, 1 + int'($urandom % 9), a < b ? a : b, a < b ? b : a,
                d < g ? d : g, d < g ? g : d, n[0]);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule